// File: doc/BRIEF.md
# Demodulator Power-Up Boot Sequencer

This block brings an external demodulator from power-off to a fully initialised state. On a boot command it puts the device's control lines in their idle-high state and holds the device in reset. It then switches the supply on and waits for it to settle. Next it releases reset and waits again for the device's internal start-up to finish. After that it probes the device's status register and loads three initialisation tables through an indirect register path. Each table goes in as a page select, a burst of data bytes, one extra zero byte, a commit command and a readiness poll.

Register transactions leave through a valid/ready request port. A downstream transaction engine takes each request and answers it later with a one-cycle done or error pulse. A request stays on the port, unchanged, until it is accepted. At most one transaction is outstanding, and the next request appears only after the response to the previous one. Responses that arrive when nothing is outstanding are ignored. A shutdown command withdraws any pending request immediately.

A numeric stage code tells the host how far the sequence got. A failure freezes that code, so the failing step can still be read after the supply has been switched off.

Top module: `demod_boot_seq`

## Requirements
- R1: After reset, `dev_rst_n` is 0, `pwr_dis` is 1, `pwr_en` is 0, every bit of `ctl_idle` is 1, `stage_code` is 0, `started` and `loaded` are 0, and no request is valid.
- R2: A boot command drives the control lines high, holds `dev_rst_n` low and switches `pwr_en` on and `pwr_dis` off, all in the same cycle. `dev_rst_n` rises only after the settle wait. The status-register read (address 0xA2) is requested only after the boot wait that follows.
- R3: The settle wait lasts SETTLE_UNITS×UNIT_CYCLES cycles (30 units by default). The boot wait lasts BOOT_UNITS×UNIT_CYCLES cycles (50 units by default). Each is measured between the output edges, with at most three cycles of pipeline slack.
- R4: `stage_code` takes the values 1 (GPIO setup), 2 (power settle, reset release and boot wait), 3 (status probe), 4, 5 and 6 (tables 0, 1 and 2), and finally 0xFF when the sequence completes.
- R5: For each table, in the order 0, 1, 2, the writes are: 0x00 to the page register 0xA6; the table bytes to the data register 0xA7, each marked as burst-continuing except the last; one separate 0x00 to 0xA7; and 0x03 to the command register 0xA8. The tables are 06 0B 17 38 9F D9 80, then 07 09 39 4F 00 65 B7 10, then 0F 0C 09.
- R6: After each commit, the block reads register 0xA8. A response with bit 0 set (busy), or an error response, causes a retry after POLL_GAP_UNITS units. The table is finished on the first error-free read with bit 0 clear. If POLL_TRIES reads all fail, the boot fails.
- R7: An error response to the probe or to any write, or an exhausted poll, ends the sequence. `pwr_en` goes to 0, `pwr_dis` goes to 1, `started` and `loaded` stay 0, `stage_code` keeps the failing stage, and no further request is issued.
- R8: `started` and `loaded` are set together when the third table's poll succeeds, and are cleared when a new boot begins.
- R9: A shutdown command aborts the sequence at any point. It sets `pwr_en` to 0 and `pwr_dis` to 1, clears `started` and `loaded`, withdraws any request and leaves `stage_code` unchanged. When a boot command and a shutdown command arrive in the same cycle, the shutdown wins.
- R10: A boot command that arrives while the sequence is running has no effect. The run still issues exactly the 27 writes of one pass, and the stage sequence does not restart.
- R11: A valid request holds its address, data, direction and burst flag until `req_ready` is seen. Only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_cmd | input | 1 | One-cycle request to start the boot sequence |
| shutdown_cmd | input | 1 | One-cycle request to abort and power down |
| req_valid | output | 1 | Register transaction request valid |
| req_ready | input | 1 | Transaction engine accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_burst | output | 1 | More bytes of the same burst follow |
| req_addr | output | 8 | Device register address |
| req_wdata | output | 8 | Write data |
| rsp_done | input | 1 | Outstanding transaction completed |
| rsp_err | input | 1 | Outstanding transaction failed |
| rsp_rdata | input | 8 | Read data, valid with rsp_done |
| stage_code | output | 8 | Progress / failure stage code |
| started | output | 1 | Device started |
| loaded | output | 1 | Initialisation tables loaded |
| pwr_en | output | 1 | Supply enable |
| pwr_dis | output | 1 | Supply disable |
| dev_rst_n | output | 1 | Device reset, active low |
| ctl_idle | output | CTL_W | Device control lines, idle high |

## Verification
The embedded assertions check, on every cycle, the invariants that need no scenario:
- request stability under back-pressure and the single outstanding transaction;
- the supply enable and disable never both on;
- reset released only with the supply on;
- the status bits implying the final stage code;
- a shutdown powering the device off on the next cycle;
- a boot during a run not restarting the stage code;
- the table index staying inside the table.

The following can only be shown by the bench's directed scenarios:
- the wait lengths;
- the exact write stream with its table bytes and burst marks;
- the order of the stage codes;
- where the stage code freezes after a probe error, a write error or a poll timeout;
- the behaviour of a shutdown mid-run and after completion.

// File: rtl/boot_pkg.sv
package boot_pkg;

  // device register addresses decoded by the indirect register path
  localparam logic [7:0] REG_STATUS = 8'hA2;
  localparam logic [7:0] REG_PAGE   = 8'hA6;
  localparam logic [7:0] REG_DATA   = 8'hA7;
  localparam logic [7:0] REG_CMD    = 8'hA8;
  localparam logic [7:0] OP_COMMIT  = 8'h03;

  // stage codes reported to the host
  localparam logic [7:0] STG_IDLE  = 8'h00;
  localparam logic [7:0] STG_GPIO  = 8'h01;
  localparam logic [7:0] STG_POWER = 8'h02;
  localparam logic [7:0] STG_PROBE = 8'h03;
  localparam logic [7:0] STG_BLK0  = 8'h04;
  localparam logic [7:0] STG_DONE  = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_GPIO, S_SETTLE, S_BOOTW, S_ISSUE, S_WAIT, S_GAP, S_DONE, S_FAIL
  } seq_state_t;

  typedef enum logic [2:0] {
    K_PROBE, K_PAGE, K_BYTE, K_TRAIL, K_COMMIT, K_POLL
  } step_t;

  typedef struct packed {
    logic       write;
    logic       burst;
    logic [7:0] addr;
    logic [7:0] data;
  } xact_t;

endpackage

// File: rtl/boot_init_rom.sv
module boot_init_rom #(
  parameter int IDX_W = 4
) (
  input  logic [1:0]       blk,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       data,
  output logic [IDX_W-1:0] len
);
  localparam int FLAT_W = IDX_W + 1;

  logic [FLAT_W-1:0] base;
  logic [FLAT_W-1:0] flat;

  function automatic logic [7:0] tbl(input logic [FLAT_W-1:0] i);
    case (i)
      0:  tbl = 8'h06;  1:  tbl = 8'h0B;  2:  tbl = 8'h17;  3:  tbl = 8'h38;
      4:  tbl = 8'h9F;  5:  tbl = 8'hD9;  6:  tbl = 8'h80;
      7:  tbl = 8'h07;  8:  tbl = 8'h09;  9:  tbl = 8'h39;  10: tbl = 8'h4F;
      11: tbl = 8'h00;  12: tbl = 8'h65;  13: tbl = 8'hB7;  14: tbl = 8'h10;
      15: tbl = 8'h0F;  16: tbl = 8'h0C;  17: tbl = 8'h09;
      default: tbl = 8'h00;
    endcase
  endfunction

  always_comb begin
    case (blk)
      2'd0:    begin base = FLAT_W'(0);  len = IDX_W'(7); end
      2'd1:    begin base = FLAT_W'(7);  len = IDX_W'(8); end
      default: begin base = FLAT_W'(15); len = IDX_W'(3); end
    endcase
    flat = base + FLAT_W'(idx);
    data = tbl(flat);
  end

endmodule

// File: rtl/boot_unit_timer.sv
module boot_unit_timer #(
  parameter int UNIT_CYCLES = 48000,
  parameter int UNITS_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               abort,
  input  logic               start,
  input  logic [UNITS_W-1:0] units,
  output logic               fire
);
  localparam longint MAXC  = (longint'(1) << UNITS_W) * UNIT_CYCLES;
  localparam int     CNT_W = $clog2(MAXC + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(units) * CNT_W'(UNIT_CYCLES) - CNT_W'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end
  end

  // R3: a new wait is started only when the previous one has expired
  a_r3_start_at_expiry: assert property (@(posedge clk) disable iff (rst)
    start |-> (!busy || cnt == '0));

endmodule

// File: rtl/boot_xact_port.sv
module boot_xact_port
  import boot_pkg::*;
#(
  parameter logic [7:0] BUSY_MASK = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       issue,
  input  xact_t      cmd,
  output logic       req_valid,
  input  logic       req_ready,
  output logic       req_write,
  output logic       req_burst,
  output logic [7:0] req_addr,
  output logic [7:0] req_wdata,
  input  logic       rsp_done,
  input  logic       rsp_err,
  input  logic [7:0] rsp_rdata,
  output logic       res_ok,
  output logic       res_err,
  output logic       res_busy
);
  xact_t held;
  logic  waiting;

  assign req_write = held.write;
  assign req_burst = held.burst;
  assign req_addr  = held.addr;
  assign req_wdata = held.data;

  assign res_ok   = waiting && rsp_done && !rsp_err;
  assign res_err  = waiting && rsp_err;
  assign res_busy = |(rsp_rdata & BUSY_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= '0;
      req_valid <= 1'b0;
      waiting   <= 1'b0;
    end else if (abort) begin
      req_valid <= 1'b0;
      waiting   <= 1'b0;
    end else if (issue) begin
      held      <= cmd;
      req_valid <= 1'b1;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
      waiting   <= 1'b1;
    end else if (waiting && (rsp_done || rsp_err)) begin
      waiting   <= 1'b0;
    end
  end

  // R11: a stalled request keeps its contents
  a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !abort) |=>
      (req_valid && $stable(req_addr) && $stable(req_wdata) &&
       $stable(req_write) && $stable(req_burst)));

  // R11: one transaction in flight at a time
  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!req_valid && !waiting));

  a_r11_no_request_while_waiting: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !req_valid);

endmodule

// File: rtl/demod_boot_seq.sv
module demod_boot_seq
  import boot_pkg::*;
#(
  parameter int         UNIT_CYCLES    = 48000,
  parameter int         SETTLE_UNITS   = 30,
  parameter int         BOOT_UNITS     = 50,
  parameter int         POLL_TRIES     = 10,
  parameter int         POLL_GAP_UNITS = 2,
  parameter int         CTL_W          = 3,
  parameter logic [7:0] BUSY_MASK      = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_cmd,
  input  logic             shutdown_cmd,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic             req_burst,
  output logic [7:0]       req_addr,
  output logic [7:0]       req_wdata,
  input  logic             rsp_done,
  input  logic             rsp_err,
  input  logic [7:0]       rsp_rdata,
  output logic [7:0]       stage_code,
  output logic             started,
  output logic             loaded,
  output logic             pwr_en,
  output logic             pwr_dis,
  output logic             dev_rst_n,
  output logic [CTL_W-1:0] ctl_idle
);
  localparam int                IDX_W     = 4;
  localparam int                UNITS_W   = 8;
  localparam int                POLL_W    = $clog2(POLL_TRIES + 1);
  localparam logic [1:0]        LAST_BLK  = 2'd2;
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_TRIES - 1);

  seq_state_t        st;
  step_t             kind;
  logic [1:0]        blk;
  logic [IDX_W-1:0]  idx;
  logic [POLL_W-1:0] polls;

  logic [7:0]         rom_byte;
  logic [IDX_W-1:0]   rom_len;
  logic [IDX_W-1:0]   last_idx;
  xact_t              cmd;
  logic               issue;
  logic               res_ok, res_err, res_busy;
  logic               t_start, t_fire;
  logic [UNITS_W-1:0] t_units;
  logic               running;
  logic               poll_retry;

  boot_init_rom #(.IDX_W(IDX_W)) u_rom (
    .blk (blk),
    .idx (idx),
    .data(rom_byte),
    .len (rom_len)
  );

  boot_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES), .UNITS_W(UNITS_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .abort(shutdown_cmd),
    .start(t_start),
    .units(t_units),
    .fire (t_fire)
  );

  boot_xact_port #(.BUSY_MASK(BUSY_MASK)) u_port (
    .clk      (clk),
    .rst      (rst),
    .abort    (shutdown_cmd),
    .issue    (issue),
    .cmd      (cmd),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_burst(req_burst),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .res_ok   (res_ok),
    .res_err  (res_err),
    .res_busy (res_busy)
  );

  assign last_idx = rom_len - IDX_W'(1);
  assign running  = (st != S_IDLE) && (st != S_DONE) && (st != S_FAIL);
  assign issue    = (st == S_ISSUE) && !shutdown_cmd;
  assign poll_retry = (st == S_WAIT) && (kind == K_POLL) &&
                      (res_err || (res_ok && res_busy)) && (polls != POLL_LAST);

  // request contents for the current step
  always_comb begin
    cmd = '0;
    case (kind)
      K_PROBE:  begin cmd.addr = REG_STATUS; end
      K_PAGE:   begin cmd.write = 1'b1; cmd.addr = REG_PAGE; end
      K_BYTE:   begin
        cmd.write = 1'b1;
        cmd.addr  = REG_DATA;
        cmd.data  = rom_byte;
        cmd.burst = (idx != last_idx);
      end
      K_TRAIL:  begin cmd.write = 1'b1; cmd.addr = REG_DATA; end
      K_COMMIT: begin cmd.write = 1'b1; cmd.addr = REG_CMD; cmd.data = OP_COMMIT; end
      default:  begin cmd.addr = REG_CMD; end
    endcase
  end

  // wait scheduling
  always_comb begin
    t_start = 1'b0;
    t_units = '0;
    if (!shutdown_cmd) begin
      if (st == S_GPIO) begin
        t_start = 1'b1;
        t_units = UNITS_W'(SETTLE_UNITS);
      end else if (st == S_SETTLE && t_fire) begin
        t_start = 1'b1;
        t_units = UNITS_W'(BOOT_UNITS);
      end else if (poll_retry) begin
        t_start = 1'b1;
        t_units = UNITS_W'(POLL_GAP_UNITS);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind       <= K_PROBE;
      blk        <= '0;
      idx        <= '0;
      polls      <= '0;
      stage_code <= STG_IDLE;
      started    <= 1'b0;
      loaded     <= 1'b0;
      pwr_en     <= 1'b0;
      pwr_dis    <= 1'b1;
      dev_rst_n  <= 1'b0;
      ctl_idle   <= '1;
    end else if (shutdown_cmd) begin
      st      <= S_IDLE;
      pwr_en  <= 1'b0;
      pwr_dis <= 1'b1;
      started <= 1'b0;
      loaded  <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE, S_FAIL: begin
          if (boot_cmd) begin
            st         <= S_GPIO;
            stage_code <= STG_GPIO;
            started    <= 1'b0;
            loaded     <= 1'b0;
          end
        end
        S_GPIO: begin
          ctl_idle   <= '1;
          dev_rst_n  <= 1'b0;
          pwr_en     <= 1'b1;
          pwr_dis    <= 1'b0;
          stage_code <= STG_POWER;
          st         <= S_SETTLE;
        end
        S_SETTLE: begin
          if (t_fire) begin
            dev_rst_n <= 1'b1;
            st        <= S_BOOTW;
          end
        end
        S_BOOTW: begin
          if (t_fire) begin
            kind       <= K_PROBE;
            stage_code <= STG_PROBE;
            st         <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (res_ok || res_err) begin
            if (kind == K_POLL) begin
              if (res_ok && !res_busy) begin
                polls <= '0;
                if (blk == LAST_BLK) begin
                  st         <= S_DONE;
                  stage_code <= STG_DONE;
                  started    <= 1'b1;
                  loaded     <= 1'b1;
                end else begin
                  blk        <= blk + 2'd1;
                  stage_code <= stage_code + 8'd1;
                  kind       <= K_PAGE;
                  st         <= S_ISSUE;
                end
              end else if (polls == POLL_LAST) begin
                st      <= S_FAIL;
                pwr_en  <= 1'b0;
                pwr_dis <= 1'b1;
              end else begin
                polls <= polls + POLL_W'(1);
                st    <= S_GAP;
              end
            end else if (res_err) begin
              st      <= S_FAIL;
              pwr_en  <= 1'b0;
              pwr_dis <= 1'b1;
            end else begin
              st <= S_ISSUE;
              case (kind)
                K_PROBE: begin
                  blk        <= '0;
                  stage_code <= STG_BLK0;
                  kind       <= K_PAGE;
                end
                K_PAGE: begin
                  idx  <= '0;
                  kind <= K_BYTE;
                end
                K_BYTE: begin
                  if (idx == last_idx) kind <= K_TRAIL;
                  else                 idx  <= idx + IDX_W'(1);
                end
                K_TRAIL: kind <= K_COMMIT;
                default: begin
                  polls <= '0;
                  kind  <= K_POLL;
                end
              endcase
            end
          end
        end
        S_GAP: begin
          if (t_fire) st <= S_ISSUE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: supply enable and disable are never on together
  a_r7_power_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pwr_en && pwr_dis));

  // R7: a failed sequence issues nothing more
  a_r7_fail_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_FAIL) |-> !req_valid);

  // R2: reset is released only with the supply on
  a_r2_release_with_power: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_rst_n) |-> (pwr_en && !pwr_dis));

  // R8: status bits imply the final stage code and a powered device
  a_r8_status_means_done: assert property (@(posedge clk) disable iff (rst)
    started |-> (loaded && stage_code == STG_DONE && pwr_en));

  // R9: shutdown powers off on the next cycle
  a_r9_shutdown_off: assert property (@(posedge clk) disable iff (rst)
    shutdown_cmd |=> (!pwr_en && pwr_dis && !started && !loaded && !req_valid));

  // R10: a boot during a run does not restart the stage code
  a_r10_boot_ignored: assert property (@(posedge clk) disable iff (rst)
    (running && boot_cmd && !shutdown_cmd) |=> (stage_code != STG_GPIO));

  // R5: table index stays inside the current table
  a_r5_index_in_table: assert property (@(posedge clk) disable iff (rst)
    (st == S_ISSUE && kind == K_BYTE) |-> (idx < rom_len));

endmodule

// File: tb/tb_demod_boot_seq.sv
module tb_demod_boot_seq;
  localparam int UNIT   = 4;
  localparam int SETTLE = 30;
  localparam int BOOTW  = 50;
  localparam int TRIES  = 4;
  localparam int GAP    = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       boot_cmd = 1'b0;
  logic       shutdown_cmd = 1'b0;
  logic       req_valid, req_write, req_burst;
  logic       req_ready = 1'b1;
  logic [7:0] req_addr, req_wdata;
  logic       rsp_done = 1'b0;
  logic       rsp_err = 1'b0;
  logic [7:0] rsp_rdata = 8'h00;
  logic [7:0] stage_code;
  logic       started, loaded, pwr_en, pwr_dis, dev_rst_n;
  logic [2:0] ctl_idle;

  always #5 clk = ~clk;

  demod_boot_seq #(
    .UNIT_CYCLES(UNIT), .SETTLE_UNITS(SETTLE), .BOOT_UNITS(BOOTW),
    .POLL_TRIES(TRIES), .POLL_GAP_UNITS(GAP), .CTL_W(3), .BUSY_MASK(8'h01)
  ) dut (
    .clk(clk), .rst(rst), .boot_cmd(boot_cmd), .shutdown_cmd(shutdown_cmd),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .stage_code(stage_code), .started(started), .loaded(loaded),
    .pwr_en(pwr_en), .pwr_dis(pwr_dis), .dev_rst_n(dev_rst_n), .ctl_idle(ctl_idle)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // responder model
  bit         ready_toggle = 0;
  bit         fail_status_read = 0;
  int         fail_wr_at = -1;
  bit         poll_always_busy = 0;
  int         busy_left = 0;
  int         n_wr = 0, n_rd = 0, n_poll = 0;
  logic [7:0] wr_addr [64];
  logic [7:0] wr_data [64];
  bit         wr_burst [64];
  int         rsp_cnt = 0;
  bit         rsp_is_err = 0;
  logic [7:0] rsp_val = 8'h00;

  always @(negedge clk) begin
    rsp_done = 1'b0;
    rsp_err  = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        if (rsp_is_err) rsp_err = 1'b1; else rsp_done = 1'b1;
        rsp_rdata = rsp_val;
      end
    end
    if (ready_toggle) req_ready = ~req_ready; else req_ready = 1'b1;
    if (req_valid && req_ready && !rst) begin
      if (req_write) begin
        if (n_wr < 64) begin
          wr_addr[n_wr]  = req_addr;
          wr_data[n_wr]  = req_wdata;
          wr_burst[n_wr] = req_burst;
        end
        rsp_is_err = (n_wr == fail_wr_at);
        rsp_val = 8'h00;
        n_wr++;
      end else if (req_addr == 8'hA8) begin
        n_poll++;
        rsp_is_err = 0;
        if (poll_always_busy) rsp_val = 8'h01;
        else if (busy_left > 0) begin busy_left--; rsp_val = 8'h01; end
        else rsp_val = 8'h00;
      end else begin
        n_rd++;
        rsp_is_err = fail_status_read;
        rsp_val = 8'h5A;
      end
      rsp_cnt = 2;
    end
  end

  // monitor: stage trace and edge times
  logic [7:0] trace [16];
  int         n_tr = 0;
  logic [7:0] last_stage = 8'h00;
  bit         prev_pwr = 0, prev_rel = 0;
  int         t_pwr = -1, t_rel = -1, t_probe = -1;
  bit         rst_low_at_pwr = 0;
  bit         ctl_high_at_pwr = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (stage_code != last_stage) begin
        if (n_tr < 16) trace[n_tr] = stage_code;
        n_tr++;
        last_stage = stage_code;
      end
      if (pwr_en && !prev_pwr) begin
        t_pwr = cyc;
        rst_low_at_pwr = !dev_rst_n && !pwr_dis;
        ctl_high_at_pwr = (ctl_idle == 3'b111);
      end
      if (dev_rst_n && !prev_rel) t_rel = cyc;
      if (t_probe < 0 && req_valid && !req_write && req_addr == 8'hA2) t_probe = cyc;
      prev_pwr = pwr_en;
      prev_rel = dev_rst_n;
    end
  end

  // expected write stream (from R5)
  logic [7:0] tblv [18] = '{8'h06, 8'h0B, 8'h17, 8'h38, 8'h9F, 8'hD9, 8'h80,
                            8'h07, 8'h09, 8'h39, 8'h4F, 8'h00, 8'h65, 8'hB7, 8'h10,
                            8'h0F, 8'h0C, 8'h09};
  int         tlen [3] = '{7, 8, 3};
  logic [7:0] ex_addr [27];
  logic [7:0] ex_data [27];
  bit         ex_burst [27];

  task automatic build_expected();
    int k = 0;
    int t = 0;
    for (int b = 0; b < 3; b++) begin
      ex_addr[k] = 8'hA6; ex_data[k] = 8'h00; ex_burst[k] = 0; k++;
      for (int i = 0; i < tlen[b]; i++) begin
        ex_addr[k] = 8'hA7; ex_data[k] = tblv[t]; ex_burst[k] = (i != tlen[b] - 1);
        k++; t++;
      end
      ex_addr[k] = 8'hA7; ex_data[k] = 8'h00; ex_burst[k] = 0; k++;
      ex_addr[k] = 8'hA8; ex_data[k] = 8'h03; ex_burst[k] = 0; k++;
    end
  endtask

  task automatic clear_log();
    n_wr = 0; n_rd = 0; n_poll = 0; n_tr = 0;
    last_stage = stage_code;
    t_pwr = -1; t_rel = -1; t_probe = -1;
    fail_status_read = 0; fail_wr_at = -1; poll_always_busy = 0;
    busy_left = 0; ready_toggle = 0;
  endtask

  task automatic pulse_boot();
    @(negedge clk) boot_cmd = 1'b1;
    @(negedge clk) boot_cmd = 1'b0;
  endtask

  task automatic pulse_shutdown();
    @(negedge clk) shutdown_cmd = 1'b1;
    @(negedge clk) shutdown_cmd = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (started || pwr_dis) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_stage(input logic [7:0] s);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (stage_code == s) break;
    end
  endtask

  task automatic check_stream(input string req);
    int bad = 0;
    for (int i = 0; i < 27; i++)
      if (wr_addr[i] != ex_addr[i] || wr_data[i] != ex_data[i] || wr_burst[i] != ex_burst[i])
        bad++;
    chk(bad == 0, req, "write stream mismatches", bad, 0);
  endtask

  task automatic check_full_trace(input string req);
    bit ok = (n_tr == 7);
    if (ok) ok = trace[0] == 8'h01 && trace[1] == 8'h02 && trace[2] == 8'h03 &&
                 trace[3] == 8'h04 && trace[4] == 8'h05 && trace[5] == 8'h06 &&
                 trace[6] == 8'hFF;
    chk(ok, req, "stage trace length/order", n_tr, 7);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(dev_rst_n == 0, "R1", "dev_rst_n", dev_rst_n, 0);
    chk(pwr_dis == 1 && pwr_en == 0, "R1", "pwr_en/pwr_dis", {pwr_en, pwr_dis}, 2'b01);
    chk(ctl_idle == 3'b111, "R1", "ctl_idle", ctl_idle, 3'b111);
    chk(stage_code == 8'h00, "R1", "stage_code", stage_code, 0);
    chk(!started && !loaded && !req_valid, "R1", "status/valid",
        {started, loaded, req_valid}, 0);
  endtask

  task automatic t_success();
    clear_log();
    pulse_boot();
    wait_end();
    chk(started && loaded, "R8", "started/loaded", {started, loaded}, 2'b11);
    chk(pwr_en && !pwr_dis && dev_rst_n, "R2", "power on, reset released",
        {pwr_en, pwr_dis, dev_rst_n}, 3'b101);
    chk(rst_low_at_pwr && ctl_high_at_pwr, "R2", "reset low and lines high at power-on",
        {rst_low_at_pwr, ctl_high_at_pwr}, 2'b11);
    chk(t_rel - t_pwr >= SETTLE*UNIT && t_rel - t_pwr <= SETTLE*UNIT + 3, "R3",
        "settle wait", t_rel - t_pwr, SETTLE*UNIT);
    chk(t_probe - t_rel >= BOOTW*UNIT && t_probe - t_rel <= BOOTW*UNIT + 3, "R3",
        "boot wait before probe", t_probe - t_rel, BOOTW*UNIT);
    chk(n_rd == 1, "R2", "status probe reads", n_rd, 1);
    chk(n_wr == 27, "R5", "write count", n_wr, 27);
    check_stream("R5");
    check_full_trace("R4");
    chk(n_poll == 3, "R6", "poll reads when ready at once", n_poll, 3);
  endtask

  task automatic t_shutdown_done();
    pulse_shutdown();
    @(negedge clk);
    chk(!pwr_en && pwr_dis, "R9", "power off after shutdown", {pwr_en, pwr_dis}, 2'b01);
    chk(!started && !loaded, "R9", "status cleared", {started, loaded}, 0);
    chk(stage_code == 8'hFF, "R9", "stage kept", stage_code, 8'hFF);
  endtask

  task automatic t_busy_polls();
    clear_log();
    busy_left = 2;
    pulse_boot();
    wait_end();
    chk(started && stage_code == 8'hFF, "R6", "success after busy polls", stage_code, 8'hFF);
    chk(n_poll == 5, "R6", "poll reads with two busy", n_poll, 5);
  endtask

  task automatic t_backpressure();
    clear_log();
    ready_toggle = 1;
    pulse_boot();
    wait_end();
    ready_toggle = 0;
    chk(started, "R11", "success under back-pressure", started, 1);
    chk(n_wr == 27, "R11", "write count under back-pressure", n_wr, 27);
    check_stream("R11");
  endtask

  task automatic t_boot_during_run();
    clear_log();
    pulse_boot();
    wait_stage(8'h05);
    pulse_boot();
    wait_end();
    chk(started, "R10", "completes despite extra boot", started, 1);
    chk(n_wr == 27, "R10", "single pass write count", n_wr, 27);
    check_full_trace("R10");
  endtask

  task automatic t_probe_fail();
    int w0;
    clear_log();
    fail_status_read = 1;
    pulse_boot();
    wait_end();
    chk(stage_code == 8'h03, "R7", "stage frozen at probe", stage_code, 3);
    chk(!pwr_en && pwr_dis && !started && !loaded, "R7", "power off after probe error",
        {pwr_en, pwr_dis, started, loaded}, 4'b0100);
    w0 = n_wr + n_rd + n_poll;
    repeat (60) @(negedge clk);
    chk(n_wr + n_rd + n_poll == w0 && w0 == 1, "R7", "no requests after failure",
        n_wr + n_rd + n_poll, 1);
  endtask

  task automatic t_write_fail();
    clear_log();
    fail_wr_at = 12;
    pulse_boot();
    wait_end();
    chk(stage_code == 8'h05, "R7", "stage frozen in table 1", stage_code, 5);
    chk(n_wr == 13, "R7", "writes up to failing one", n_wr, 13);
    chk(!pwr_en && pwr_dis && !started, "R7", "power off after write error",
        {pwr_en, pwr_dis, started}, 3'b010);
  endtask

  task automatic t_poll_timeout();
    clear_log();
    poll_always_busy = 1;
    pulse_boot();
    wait_end();
    chk(stage_code == 8'h04, "R6", "stage frozen in table 0", stage_code, 4);
    chk(n_poll == TRIES, "R6", "poll attempts", n_poll, TRIES);
    chk(n_wr == 10 && !pwr_en && pwr_dis, "R7", "table 0 writes then power off",
        n_wr, 10);
  endtask

  task automatic t_shutdown_mid();
    int w0;
    clear_log();
    pulse_boot();
    wait_stage(8'h05);
    pulse_shutdown();
    @(negedge clk);
    chk(!pwr_en && pwr_dis && !started, "R9", "abort powers off",
        {pwr_en, pwr_dis, started}, 3'b010);
    chk(stage_code == 8'h05, "R9", "stage kept on abort", stage_code, 5);
    w0 = n_wr;
    repeat (60) @(negedge clk);
    chk(n_wr == w0 && !req_valid, "R9", "no requests after abort", n_wr, w0);
  endtask

  task automatic t_both_same_cycle();
    clear_log();
    @(negedge clk) begin boot_cmd = 1'b1; shutdown_cmd = 1'b1; end
    @(negedge clk) begin boot_cmd = 1'b0; shutdown_cmd = 1'b0; end
    repeat (10) @(negedge clk);
    chk(!pwr_en && pwr_dis && stage_code == 8'h05 && n_tr == 0, "R9",
        "shutdown wins over boot", stage_code, 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    build_expected();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_success();
    t_shutdown_done();
    t_busy_polls();
    t_backpressure();
    t_boot_during_run();
    t_probe_fail();
    t_write_fail();
    t_poll_timeout();
    t_shutdown_mid();
    t_both_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule